// File: doc/BRIEF.md
# Spike-Timing Plasticity Weight Updater

This block is the on-line learning controller for one spiking neuron. It watches the presynaptic spike lines that feed the neuron and the neuron's own output spike. From their relative timing it decides, per synapse, whether the connection gets stronger or weaker. It keeps a private copy of every synaptic weight and pushes each new value into the neuron's weight memory over a one-cycle write strobe with address and data.

Each presynaptic line and the postsynaptic line has a small age timer that counts cycles since its last spike. A postsynaptic spike turns every recent presynaptic spike into a pending increase. A presynaptic spike that comes after a recent postsynaptic spike becomes a pending decrease. The size of the step shrinks in three bands as the gap grows. A synapse pointer walks the bank and serves one pending update per cycle. With the advance enable high, the pointer steps past synapses that have nothing pending. With it low, the pointer waits where it is.

Top module: `stdp_updater`

## Requirements
- R1: A synchronous active-high reset drives wr_en low, sets every stored weight to W_INIT (1), clears all pending updates, puts the pointer at synapse 0, and marks all spike timers as stale.
- R2: If presynaptic line k spikes in cycle t and the postsynaptic spike comes in cycle t+g, with 1 ≤ g ≤ 15, synapse k gets an increase.
- R3: If the postsynaptic spike comes in cycle t and line k spikes in cycle t+g, with 1 ≤ g ≤ 15, and there is no postsynaptic spike in cycle t+g, synapse k gets a decrease.
- R4: The step size is 3 for a gap of 0 to 3 cycles, 2 for a gap of 4 to 7, and 1 for a gap of 8 to 15.
- R5: A gap of 16 cycles or more causes no update and no write, and leaves the weight unchanged.
- R6: An increase saturates the weight at W_MAX (127).
- R7: A decrease saturates the weight at 0.
- R8: Each served update drives wr_en high for exactly one cycle. In that cycle wr_addr carries the synapse index and wr_data the new weight. These outputs appear on the clock edge after the cycle in which the pointer sits on a synapse with a pending update and learn_en is high. After each write the pointer advances by one, wrapping from N_SYN-1 to 0.
- R9: If the pointer sits on a synapse with nothing pending, it advances by one only when adv_en is high. While adv_en is low, it holds and no write occurs.
- R10: While learn_en is low, no update is captured and none is served. Spike timers keep running.
- R11: A presynaptic spike and a postsynaptic spike in the same cycle count as gap 0, which is an increase of 3.
- R12: A new event on a synapse replaces any update still pending for that synapse. An event captured in the same cycle that the old update is served stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| learn_en | input | 1 | Enables capture and service of weight updates |
| adv_en | input | 1 | Lets the pointer step past synapses with nothing pending |
| pre_spk | input | N_SYN | Presynaptic spike lines, one per synapse |
| post_spk | input | 1 | Neuron output spike |
| wr_en | output | 1 | One-cycle write strobe into the neuron weight memory |
| wr_addr | output | ADDR_W | Synapse index being written |
| wr_data | output | 8 | New weight value |

## Verification
A spike seen at a clock edge becomes a pending update at that same edge. The write appears one edge after the pointer reaches that synapse, so the delay is between one and N_SYN+1 cycles, depending on where the pointer is. The bench keeps a behavioural model that advances on the same edge. It compares wr_en, wr_addr and wr_data on every falling edge, once the registered outputs have settled. Directed scenarios wait well past the longest pointer sweep before they check the last value written to each synapse. Spike gaps are produced by counting falling edges between the pulses.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    // width of each spike age timer; saturated value marks a stale spike
    localparam int AGE_W = 4;
    localparam logic [AGE_W-1:0] AGE_SAT = {AGE_W{1'b1}};

    // step bands (inclusive upper gap of each band)
    localparam int BAND_BIG   = 3;
    localparam int BAND_MID   = 7;
    localparam int BAND_SMALL = 15;

    localparam int W_W = 8;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    typedef struct packed {
        logic       valid;
        dir_e       dir;
        logic [1:0] mag;
    } pend_t;

    function automatic logic [1:0] gap_mag(input logic [AGE_W:0] gap);
        if (int'(gap) <= BAND_BIG)        return 2'd3;
        else if (int'(gap) <= BAND_MID)   return 2'd2;
        else if (int'(gap) <= BAND_SMALL) return 2'd1;
        else                              return 2'd0;
    endfunction

    function automatic logic [W_W-1:0] next_weight(input logic [W_W-1:0] w,
                                                   input pend_t          p,
                                                   input logic [W_W-1:0] wmax);
        logic [W_W:0]   sum;
        logic [W_W-1:0] step;
        step = {{(W_W-2){1'b0}}, p.mag};
        if (p.dir == DIR_UP) begin
            sum = {1'b0, w} + {1'b0, step};
            return (sum > {1'b0, wmax}) ? wmax : sum[W_W-1:0];
        end
        return (w < step) ? '0 : (w - step);
    endfunction

endpackage

// File: rtl/stdp_age_timer.sv
module stdp_age_timer
    import stdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             spk,
    output logic [AGE_W-1:0] age
);

    always_ff @(posedge clk) begin
        if (rst)             age <= AGE_SAT;
        else if (spk)        age <= '0;
        else if (age != AGE_SAT) age <= age + 1'b1;
    end

endmodule

// File: rtl/stdp_link_sel.sv
module stdp_link_sel
    import stdp_pkg::*;
#(
    parameter int N_SYN = 8
) (
    input  logic                        learn_en,
    input  logic [N_SYN-1:0]            pre_spk,
    input  logic                        post_spk,
    input  logic [N_SYN-1:0][AGE_W-1:0] pre_age,
    input  logic [AGE_W-1:0]            post_age,
    output pend_t [N_SYN-1:0]           cap
);

    // gap since the opposite spike, as seen in the current cycle
    logic [AGE_W:0] post_gap;
    assign post_gap = {1'b0, post_age} + (AGE_W+1)'(1);

    for (genvar i = 0; i < N_SYN; i++) begin : g_link
        logic [AGE_W:0] pre_gap;
        logic [1:0]     up_mag;
        logic [1:0]     dn_mag;

        assign pre_gap = pre_spk[i] ? '0 : ({1'b0, pre_age[i]} + (AGE_W+1)'(1));
        assign up_mag  = gap_mag(pre_gap);
        assign dn_mag  = gap_mag(post_gap);

        always_comb begin
            cap[i] = '{valid: 1'b0, dir: DIR_UP, mag: 2'd0};
            if (learn_en) begin
                if (post_spk) begin
                    cap[i] = '{valid: (up_mag != 2'd0), dir: DIR_UP, mag: up_mag};
                end else if (pre_spk[i]) begin
                    cap[i] = '{valid: (dn_mag != 2'd0), dir: DIR_DN, mag: dn_mag};
                end
            end
        end
    end

endmodule

// File: rtl/stdp_weight_bank.sv
module stdp_weight_bank
    import stdp_pkg::*;
#(
    parameter int N_SYN  = 8,
    parameter int W_MAX  = 127,
    parameter int W_INIT = 1,
    parameter int ADDR_W = (N_SYN > 1) ? $clog2(N_SYN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              learn_en,
    input  logic              adv_en,
    input  pend_t [N_SYN-1:0] cap,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [W_W-1:0]    wr_data
);

    localparam logic [W_W-1:0]    WMAX_V = W_W'(W_MAX);
    localparam logic [W_W-1:0]    WINI_V = W_W'(W_INIT);
    localparam logic [ADDR_W-1:0] LAST   = ADDR_W'(N_SYN - 1);

    logic [W_W-1:0]    w_q  [N_SYN];
    pend_t             pend_q [N_SYN];
    logic [ADDR_W-1:0] ptr_q;

    pend_t             cur;
    logic              serve;
    logic [W_W-1:0]    new_w;
    logic [ADDR_W-1:0] ptr_nxt;

    always_comb begin
        cur     = pend_q[ptr_q];
        serve   = learn_en && cur.valid;
        new_w   = next_weight(w_q[ptr_q], cur, WMAX_V);
        ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SYN; i++) begin
                w_q[i]    <= WINI_V;
                pend_q[i] <= '{valid: 1'b0, dir: DIR_UP, mag: 2'd0};
            end
            ptr_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            for (int i = 0; i < N_SYN; i++) begin
                if (cap[i].valid)
                    pend_q[i] <= cap[i];
                else if (serve && (ptr_q == ADDR_W'(i)))
                    pend_q[i].valid <= 1'b0;
            end
            if (serve) begin
                w_q[ptr_q] <= new_w;
                wr_en      <= 1'b1;
                wr_addr    <= ptr_q;
                wr_data    <= new_w;
                ptr_q      <= ptr_nxt;
            end else begin
                wr_en <= 1'b0;
                if (learn_en && adv_en)
                    ptr_q <= ptr_nxt;
            end
        end
    end

endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
    import stdp_pkg::*;
#(
    parameter int N_SYN  = 8,
    parameter int W_MAX  = 127,
    parameter int W_INIT = 1,
    localparam int ADDR_W = (N_SYN > 1) ? $clog2(N_SYN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              learn_en,
    input  logic              adv_en,
    input  logic [N_SYN-1:0]  pre_spk,
    input  logic              post_spk,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [W_W-1:0]    wr_data
);

    logic [N_SYN-1:0][AGE_W-1:0] pre_age;
    logic [AGE_W-1:0]            post_age;
    pend_t [N_SYN-1:0]           cap;

    for (genvar i = 0; i < N_SYN; i++) begin : g_pre_tmr
        stdp_age_timer u_tmr (
            .clk (clk),
            .rst (rst),
            .spk (pre_spk[i]),
            .age (pre_age[i])
        );
    end

    stdp_age_timer u_post_tmr (
        .clk (clk),
        .rst (rst),
        .spk (post_spk),
        .age (post_age)
    );

    stdp_link_sel #(.N_SYN(N_SYN)) u_sel (
        .learn_en (learn_en),
        .pre_spk  (pre_spk),
        .post_spk (post_spk),
        .pre_age  (pre_age),
        .post_age (post_age),
        .cap      (cap)
    );

    stdp_weight_bank #(
        .N_SYN  (N_SYN),
        .W_MAX  (W_MAX),
        .W_INIT (W_INIT),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .learn_en (learn_en),
        .adv_en   (adv_en),
        .cap      (cap),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

endmodule

// File: rtl/stdp_updater_chk.sv
module stdp_updater_chk #(
    parameter int N_SYN = 8,
    parameter int W_MAX = 127,
    localparam int ADDR_W = (N_SYN > 1) ? $clog2(N_SYN) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              learn_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data
);

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !wr_en);

    p_upper_clamp_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_data) <= W_MAX));

    p_one_cycle_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !(wr_en && (wr_addr == $past(wr_addr))));

    p_addr_in_range_r8: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < N_SYN));

    p_learn_off_r10: assert property (@(posedge clk) disable iff (rst)
        !learn_en |=> !wr_en);

endmodule

bind stdp_updater stdp_updater_chk #(.N_SYN(N_SYN), .W_MAX(W_MAX)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .learn_en (learn_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/stdp_updater_tb.sv
module stdp_updater_tb_top;

    localparam int N  = 8;
    localparam int WM = 127;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          learn_en = 1'b1;
    logic          adv_en = 1'b1;
    logic [N-1:0]  pre_spk = '0;
    logic          post_spk = 1'b0;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    always #2 clk = ~clk;

    stdp_updater #(.N_SYN(N), .W_MAX(WM), .W_INIT(1)) dut_i (
        .clk(clk), .rst(rst), .learn_en(learn_en), .adv_en(adv_en),
        .pre_spk(pre_spk), .post_spk(post_spk),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // ---------------- behavioural reference model ----------------
    int m_age [N];
    int m_pa;
    int m_w   [N];
    int m_pv  [N];
    int m_pup [N];
    int m_pm  [N];
    int m_ptr, m_we, m_addr, m_data;

    function automatic int band(int g);
        if (g <= 3)  return 3;
        if (g <= 7)  return 2;
        if (g <= 15) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_age[i] = 15; m_w[i] = 1; m_pv[i] = 0; m_pup[i] = 0; m_pm[i] = 0;
            end
            m_pa = 15; m_ptr = 0; m_we = 0; m_addr = 0; m_data = 0;
        end else begin
            int cv [N];
            int cu [N];
            int cm [N];
            for (int i = 0; i < N; i++) begin
                int g;
                int m;
                cv[i] = 0; cu[i] = 0; cm[i] = 0;
                if (learn_en) begin
                    if (post_spk) begin
                        g = pre_spk[i] ? 0 : m_age[i] + 1;
                        m = band(g);
                        if (m != 0) begin cv[i] = 1; cu[i] = 1; cm[i] = m; end
                    end else if (pre_spk[i]) begin
                        m = band(m_pa + 1);
                        if (m != 0) begin cv[i] = 1; cu[i] = 0; cm[i] = m; end
                    end
                end
            end
            if (learn_en && m_pv[m_ptr] != 0) begin
                int nw;
                nw = m_pup[m_ptr] != 0 ? m_w[m_ptr] + m_pm[m_ptr] : m_w[m_ptr] - m_pm[m_ptr];
                if (nw > WM) nw = WM;
                if (nw < 0)  nw = 0;
                m_w[m_ptr] = nw;
                m_we = 1; m_addr = m_ptr; m_data = nw;
                m_pv[m_ptr] = 0;
                m_ptr = (m_ptr + 1) % N;
            end else begin
                m_we = 0;
                if (learn_en && adv_en) m_ptr = (m_ptr + 1) % N;
            end
            for (int i = 0; i < N; i++) begin
                if (cv[i] != 0) begin m_pv[i] = 1; m_pup[i] = cu[i]; m_pm[i] = cm[i]; end
                m_age[i] = pre_spk[i] ? 0 : (m_age[i] < 15 ? m_age[i] + 1 : 15);
            end
            m_pa = post_spk ? 0 : (m_pa < 15 ? m_pa + 1 : 15);
        end
    end

    // ---------------- per-cycle comparison and write log ----------------
    int seen_w [N];
    int wcount [N];
    int wtotal;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(wr_en == m_we[0], {cur_tag, " wr_en"}, int'(wr_en), m_we);
            if (m_we != 0 && wr_en) begin
                check(int'(wr_addr) == m_addr, {cur_tag, " wr_addr"}, int'(wr_addr), m_addr);
                check(int'(wr_data) == m_data, {cur_tag, " wr_data"}, int'(wr_data), m_data);
            end
            if (wr_en && !rst) begin
                seen_w[wr_addr] = int'(wr_data);
                wcount[wr_addr]++;
                wtotal++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_log();
        for (int i = 0; i < N; i++) begin seen_w[i] = -1; wcount[i] = 0; end
        wtotal = 0;
    endtask

    task automatic pre_pulse(input int k);
        pre_spk[k] = 1'b1; cyc(1); pre_spk = '0;
    endtask

    task automatic post_pulse();
        post_spk = 1'b1; cyc(1); post_spk = 1'b0;
    endtask

    task automatic both_pulse(input int k);
        pre_spk[k] = 1'b1; post_spk = 1'b1; cyc(1); pre_spk = '0; post_spk = 1'b0;
    endtask

    // pre on k, post g cycles later (g >= 1)
    task automatic pre_then_post(input int k, input int g);
        pre_pulse(k); cyc(g - 1); post_pulse();
    endtask

    // post, pre on k g cycles later (g >= 1)
    task automatic post_then_pre(input int k, input int g);
        post_pulse(); cyc(g - 1); pre_pulse(k);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        clr_log();
        cyc(3);
        cur_tag = "R1";
        check(wr_en == 1'b0, "R1 wr_en low in reset", int'(wr_en), 0);
        rst = 1'b0;
        cyc(3);
        check(wr_en == 1'b0, "R1 wr_en low after reset", int'(wr_en), 0);

        // R2 / R4 band 0-3: gap 2 -> 1+3
        cur_tag = "R2";
        clr_log();
        pre_then_post(2, 2);
        cyc(25);
        check(seen_w[2] == 4, "R2 potentiation gap 2", seen_w[2], 4);
        check(wcount[2] == 1, "R8 single write for one update", wcount[2], 1);
        check(wtotal == 1, "R5 stale synapses untouched", wtotal, 1);

        // R4 band 4-7: gap 5 -> 1+2
        cur_tag = "R4";
        clr_log();
        pre_then_post(5, 5);
        cyc(25);
        check(seen_w[5] == 3, "R4 gap 5 step 2", seen_w[5], 3);

        // R4 band 8-15: gap 12 -> 1+1
        clr_log();
        pre_then_post(6, 12);
        cyc(25);
        check(seen_w[6] == 2, "R4 gap 12 step 1", seen_w[6], 2);

        // R5: gap 16 -> nothing
        cur_tag = "R5";
        clr_log();
        pre_then_post(1, 16);
        cyc(25);
        check(wcount[1] == 0, "R5 gap 16 no write", wcount[1], 0);

        // R11 coincident, also shows R5 left weight at 1
        cur_tag = "R11";
        clr_log();
        both_pulse(1);
        cyc(25);
        check(seen_w[1] == 4, "R11 coincident +3 from unchanged weight", seen_w[1], 4);

        // R3 depression: syn2 at 4, gap 6 -> 4-2
        cur_tag = "R3";
        clr_log();
        post_then_pre(2, 6);
        cyc(25);
        check(seen_w[2] == 2, "R3 depression gap 6", seen_w[2], 2);

        // R6 upper clamp
        cur_tag = "R6";
        clr_log();
        for (int it = 0; it < 45; it++) begin
            both_pulse(0);
            cyc(20);
        end
        check(seen_w[0] == 127, "R6 clamp at 127", seen_w[0], 127);

        // R7 lower clamp
        cur_tag = "R7";
        clr_log();
        for (int it = 0; it < 45; it++) begin
            post_then_pre(0, 1);
            cyc(20);
        end
        check(seen_w[0] == 0, "R7 clamp at 0", seen_w[0], 0);

        // R12 / R9: reset, hold pointer at 0, overwrite pending on syn3
        cur_tag = "R12";
        rst = 1'b1; cyc(2); rst = 1'b0;
        adv_en = 1'b0;
        clr_log();
        pre_then_post(3, 2);   // +3 pending
        cyc(2);
        pre_pulse(3);          // post 3 cycles earlier -> -3 replaces
        cyc(10);
        check(wtotal == 0, "R9 pointer holds with adv_en low", wtotal, 0);
        adv_en = 1'b1;
        cyc(25);
        check(seen_w[3] == 0, "R12 latest event replaces pending", seen_w[3], 0);

        // R1: weights restored by reset (syn5 was 3)
        cur_tag = "R1";
        clr_log();
        both_pulse(5);
        cyc(25);
        check(seen_w[5] == 4, "R1 weight restored to 1 by reset", seen_w[5], 4);

        // R10: learning disabled
        cur_tag = "R10";
        clr_log();
        learn_en = 1'b0;
        pre_then_post(7, 1);
        cyc(25);
        check(wcount[7] == 0, "R10 no write while learn off", wcount[7], 0);
        learn_en = 1'b1;
        cyc(25);
        check(wcount[7] == 0, "R10 nothing captured while learn off", wcount[7], 0);
        both_pulse(7);
        cyc(25);
        check(seen_w[7] == 4, "R10 weight untouched while learn off", seen_w[7], 4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule